// File: doc/BRIEF.md
# Standby Horizontal Drive with Reference Qualification

This block produces the horizontal deflection drive while the display path is in standby or is still powering up. It samples a 5 MHz reference clock with a four-times-faster system clock, passes it through a synchronizer, and keeps its drive output low until the reference has shown a clean high pulse of exactly two fast-clock cycles. Once the reference has been accepted, a clock-release flag rises. The reference's rising edges are then counted modulo five to form a 1 MHz standby tick.

The standby tick times a square wave whose period, in ticks, is set by an input word. The high and low phases each last half of that period. The drive runs only while the release flag and the standby flag are both high. If the reference stops toggling, a timeout withdraws the release flag and the drive returns low.

The edge counter behind the standby tick has no reset. It keeps its phase across the general reset. There are no protection or shutdown inputs.

Qualifier FSM states and transitions:
- HUNT → MEASURE on a synchronized rising edge.
- MEASURE → RELEASED when a falling edge arrives two cycles after the rise.
- MEASURE → HUNT when a falling edge arrives one cycle after the rise, or when no falling edge has arrived by the second cycle.
- RELEASED → HUNT after the timeout.

Line generator FSM states and transitions:
- OFF → HIGH on the first tick while enabled.
- HIGH → LOW on the tick that ends the phase, and LOW → HIGH likewise.
- Any state → OFF when the generator is disabled.

Top module: `hs_stby_hdrive`

## Requirements
- R1: While rst_n is low, and after it rises until qualification completes, clk_ok and hdrive are both 0.
- R2: clk_ok rises only after a synchronized rising edge of ref_in is followed exactly two clk cycles later by a falling edge. A reference whose high time is 1 or 3 clk cycles never raises clk_ok.
- R3: The standby tick occurs once per 5 rising edges of ref_in, and hdrive changes only on a tick. hdrive is 0 in the cycle clk_ok rises, and its first high phase starts at the first tick after release.
- R4: With line_ticks = P, the high and low phases of hdrive each last max(floor(P/2),1) ticks. That is 20 clk cycles per tick with a 4-cycle reference. The period is sampled at the start of each phase.
- R5: rst_n does not clear the tick divider. Ticks stay aligned to every fifth reference rising edge counted from power-up, including across a reset.
- R6: If no reference edge is seen for TIMEOUT_CYC consecutive clk cycles, clk_ok falls, and hdrive is 0 from the next cycle on.
- R7: While stby is 0, hdrive is 0 and clk_ok is unaffected. When stby returns to 1, the drive restarts with a high phase at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock (4× the reference) |
| rst_n | input | 1 | Asynchronous active-low general reset |
| ref_in | input | 1 | Asynchronous 5 MHz reference |
| stby | input | 1 | Standby mode enable for the drive |
| line_ticks | input | PERIOD_W | Line period in standby ticks |
| hdrive | output | 1 | Horizontal drive, 50% duty |
| clk_ok | output | 1 | Reference qualified (clock release) |

## Verification
A qualifier stuck in the wrong state shows on clk_ok within a cycle or two of the reference pulse that should have decided it. A wrong divider phase moves the hdrive edges off the fifth-edge grid at the very next tick, which is at most 20 cycles later. A corrupted phase counter changes the measured high or low width within one half period. The bench therefore measures hdrive widths edge to edge for several periods, and checks the reference-edge index at each checked hdrive rise, including across a mid-run reset.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        Q_HUNT     = 2'd0,
        Q_MEASURE  = 2'd1,
        Q_RELEASED = 2'd2
    } qual_state_t;

    typedef enum logic [1:0] {
        G_OFF  = 2'd0,
        G_HIGH = 2'd1,
        G_LOW  = 2'd2
    } gen_state_t;

endpackage

// File: rtl/hs_edge_sync.sv
module hs_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic ref_in,
    output logic rise,
    output logic fall
);
    // No reset: the chain feeds the free-running divider.
    logic [STAGES:0] chain = '0;

    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-1:0], ref_in};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/hs_stby_divider.sv
module hs_stby_divider #(
    parameter int DIV = 5
) (
    input  logic clk,
    input  logic rise,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    // Intentionally outside the general reset; self-corrects from any value.
    logic [CW-1:0] cnt = '0;

    always_ff @(posedge clk) begin
        if (rise) begin
            if (cnt >= LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end

    assign tick = rise && (cnt >= LAST);
endmodule

// File: rtl/hs_ref_qualifier.sv
module hs_ref_qualifier
    import hs_pkg::*;
#(
    parameter int TIMEOUT_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic fall,
    output logic released
);
    localparam int TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [TW-1:0] IDLE_LAST = TW'(TIMEOUT_CYC - 1);

    qual_state_t state, state_n;
    logic [1:0]    gap;
    logic [TW-1:0] idle;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_HUNT;
        else        state <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            Q_HUNT: begin
                if (rise) state_n = Q_MEASURE;
            end
            Q_MEASURE: begin
                if (fall)               state_n = (gap == 2'd2) ? Q_RELEASED : Q_HUNT;
                else if (gap >= 2'd2)   state_n = Q_HUNT;
            end
            Q_RELEASED: begin
                if (!(rise || fall) && idle == IDLE_LAST) state_n = Q_HUNT;
            end
            default: state_n = Q_HUNT;
        endcase
    end

    // Counters and registered output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap      <= 2'd1;
            idle     <= '0;
            released <= 1'b0;
        end else begin
            released <= (state_n == Q_RELEASED);
            gap      <= (state == Q_MEASURE) ? gap + 2'd1 : 2'd1;
            if (state != Q_RELEASED || rise || fall) idle <= '0;
            else                                      idle <= idle + 1'b1;
        end
    end
endmodule

// File: rtl/hs_line_gen.sv
module hs_line_gen
    import hs_pkg::*;
#(
    parameter int PW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic [PW-1:0] line_ticks,
    output logic          hdrive
);
    gen_state_t state, state_n;
    logic [PW-1:0] cnt;
    logic [PW-1:0] half;

    always_comb begin
        half = line_ticks >> 1;
        if (half == '0) half = PW'(1);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= G_OFF;
        else        state <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        if (!en) begin
            state_n = G_OFF;
        end else begin
            unique case (state)
                G_OFF:  if (tick)                 state_n = G_HIGH;
                G_HIGH: if (tick && cnt == '0)    state_n = G_LOW;
                G_LOW:  if (tick && cnt == '0)    state_n = G_HIGH;
                default:                          state_n = G_OFF;
            endcase
        end
    end

    // Phase counter and registered drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            hdrive <= 1'b0;
        end else begin
            hdrive <= (state_n == G_HIGH);
            if (en && tick) begin
                if (state == G_OFF || cnt == '0) cnt <= half - 1'b1;
                else                             cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/hs_stby_hdrive.sv
module hs_stby_hdrive #(
    parameter int PERIOD_W    = 10,
    parameter int TIMEOUT_CYC = 32,
    parameter int REF_DIV     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_in,
    input  logic                stby,
    input  logic [PERIOD_W-1:0] line_ticks,
    output logic                hdrive,
    output logic                clk_ok
);
    logic edge_rise, edge_fall, sb_tick, gen_en;

    hs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .ref_in(ref_in),
        .rise  (edge_rise),
        .fall  (edge_fall)
    );

    hs_stby_divider #(.DIV(REF_DIV)) u_div (
        .clk (clk),
        .rise(edge_rise),
        .tick(sb_tick)
    );

    hs_ref_qualifier #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (edge_rise),
        .fall    (edge_fall),
        .released(clk_ok)
    );

    assign gen_en = clk_ok & stby;

    hs_line_gen #(.PW(PERIOD_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (gen_en),
        .tick      (sb_tick),
        .line_ticks(line_ticks),
        .hdrive    (hdrive)
    );
endmodule

// File: rtl/hs_stby_hdrive_chk.sv
module hs_stby_hdrive_chk (
    input logic clk,
    input logic rst_n,
    input logic stby,
    input logic hdrive,
    input logic clk_ok,
    input logic rise,
    input logic fall,
    input logic tick
);
    // R1 / R6: drive is held low whenever the reference is not qualified
    a_r1_low_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_ok |=> !hdrive);

    // R2: release follows a rise and a fall spaced two cycles apart
    a_r2_release_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_ok) |-> ($past(fall) && $past(rise, 3)));

    // R3: drive is low at release
    a_r3_low_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_ok) |-> !hdrive);

    // R3: drive edges only follow a standby tick
    a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdrive) |-> $past(tick));

    a_r3_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hdrive) && $past(clk_ok && stby) |-> $past(tick));

    // R7: standby low forces the drive low
    a_r7_stby_off: assert property (@(posedge clk) disable iff (!rst_n)
        !stby |=> !hdrive);
endmodule

bind hs_stby_hdrive hs_stby_hdrive_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .stby  (stby),
    .hdrive(hdrive),
    .clk_ok(clk_ok),
    .rise  (edge_rise),
    .fall  (edge_fall),
    .tick  (sb_tick)
);

// File: tb/sim_hs_stby_hdrive.sv
module sim_hs_stby_hdrive;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ref_in;
    logic       stby;
    logic [9:0] line_ticks;
    logic       hdrive;
    logic       clk_ok;

    int  errs = 0;
    int  checks = 0;
    int  rise_idx = 0;
    int  hi_len = 2;
    int  lo_len = 2;
    bit  run = 1'b1;

    always #2 clk = ~clk;

    hs_stby_hdrive u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (ref_in),
        .stby      (stby),
        .line_ticks(line_ticks),
        .hdrive    (hdrive),
        .clk_ok    (clk_ok)
    );

    // {line_ticks, expected high cycles, expected low cycles}; 20 cycles per tick
    localparam int NV = 6;
    localparam int VEC [NV][3] = '{
        '{8, 80, 80},
        '{9, 80, 80},
        '{4, 40, 40},
        '{1, 20, 20},
        '{3, 20, 20},
        '{12, 120, 120}
    };

    // Reference generator
    initial begin
        ref_in = 1'b0;
        forever begin
            @(posedge clk); #1;
            if (run) begin
                ref_in = 1'b1;
                rise_idx++;
                repeat (hi_len) @(posedge clk);
                #1 ref_in = 1'b0;
                repeat (lo_len - 1) @(posedge clk);
            end else begin
                ref_in = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_hd(input logic lvl, input int maxc, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (hdrive == lvl) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic wait_ok(input int maxc, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (clk_ok) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic measure(input logic lvl, output int n);
        n = 0;
        while (hdrive == lvl && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Wait for a fresh hdrive rise
    task automatic next_rise(output bit ok);
        bit a;
        wait_hd(1'b0, 400, a);
        wait_hd(1'b1, 400, ok);
        ok = ok && a;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        bit ok;
        int n, hi, lo, cnt;
        rst_n = 1'b0;
        stby = 1'b1;
        line_ticks = 10'd8;

        // R1: reset state
        repeat (8) @(negedge clk);
        chk(!clk_ok && !hdrive, "R1 reset outputs low", {clk_ok, hdrive}, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R2 / R3: qualification and first pulse
        wait_ok(60, ok);
        chk(ok, "R2 release with 2-cycle pulse", ok, 1);
        chk(!hdrive, "R3 drive low at release", hdrive, 0);
        wait_hd(1'b1, 60, ok);
        chk(ok, "R3 first high after release", ok, 1);
        chk(rise_idx % 5 == 0, "R3 rise on fifth reference edge", rise_idx % 5, 0);

        // R4: table-driven period/duty walk
        for (int v = 0; v < NV; v++) begin
            line_ticks = 10'(VEC[v][0]);
            next_rise(ok);
            measure(1'b1, hi);
            measure(1'b0, lo);
            chk(ok && hi == VEC[v][1], "R4 high phase width", hi, VEC[v][1]);
            chk(lo == VEC[v][2], "R4 low phase width", lo, VEC[v][2]);
        end

        // R7: standby low forces drive low, clk_ok kept
        line_ticks = 10'd4;
        stby = 1'b0;
        repeat (2) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (hdrive) cnt++;
        end
        chk(cnt == 0, "R7 drive low while stby=0", cnt, 0);
        chk(clk_ok, "R7 clk_ok unaffected by stby", clk_ok, 1);
        stby = 1'b1;
        wait_hd(1'b1, 60, ok);
        chk(ok && rise_idx % 5 == 0, "R7 restart on tick", rise_idx % 5, 0);
        measure(1'b1, hi);
        chk(hi == 40, "R7 restart high phase width", hi, 40);

        // R5: divider keeps phase across reset
        n = 0;
        while (rise_idx % 5 != 1 && n < 100) begin
            @(negedge clk);
            n++;
        end
        rst_n = 1'b0;
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (clk_ok || hdrive) cnt++;
        end
        chk(cnt == 0, "R1 outputs low during mid-run reset", cnt, 0);
        rst_n = 1'b1;
        wait_ok(60, ok);
        chk(ok, "R2 requalify after reset", ok, 1);
        wait_hd(1'b1, 60, ok);
        chk(ok && rise_idx % 5 == 0, "R5 tick alignment across reset", rise_idx % 5, 0);

        // R6: timeout on a stopped reference
        run = 1'b0;
        repeat (10) @(negedge clk);
        chk(clk_ok, "R6 clk_ok held before timeout", clk_ok, 1);
        repeat (40) @(negedge clk);
        chk(!clk_ok, "R6 clk_ok drops after timeout", clk_ok, 0);
        chk(!hdrive, "R6 drive low after timeout", hdrive, 0);

        // R2: wrong pulse widths never release
        hi_len = 3; lo_len = 3; run = 1'b1;
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (clk_ok || hdrive) cnt++;
        end
        chk(cnt == 0, "R2 3-cycle high rejected", cnt, 0);
        hi_len = 1; lo_len = 3;
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (clk_ok || hdrive) cnt++;
        end
        chk(cnt == 0, "R2 1-cycle high rejected", cnt, 0);
        hi_len = 2; lo_len = 2;
        wait_ok(40, ok);
        chk(ok, "R2 release after valid pulse resumes", ok, 1);
        wait_hd(1'b1, 60, ok);
        chk(ok && rise_idx % 5 == 0, "R5 tick alignment after bad patterns", rise_idx % 5, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule